// File: doc/BRIEF.md
# Closed-Loop Fan Duty Controller

This block sets the 8-bit PWM duty of a single fan so that its measured tachometer count tracks a target count. A larger count means a slower fan. Each time a new measurement is strobed in, the duty moves one step toward the target. The tachometer front end and the PWM waveform generator sit outside the block.

The target comes from one of two sources. In speed mode it is one programmed count. In temperature mode it is chosen by a temperature reading. Three programmed boundaries, plus two midpoints the block computes from them, split the temperature range into six zones, and each zone has its own count. Two count values are reserved: all ones turns the fan off and all zeros runs it at full duty.

The duty is held for a programmable number of time-base ticks after it drops to zero and after it jumps up to the start duty. A fault flag reports a fan that is still too slow after running at full duty for a programmable number of ticks. All timing is counted in ticks of an external enable pulse.

Top module: `fan_duty_ctrl`

## Requirements
- R1: After reset, `duty` is FFh and `fan_fault` is 0.
- R2: The two derived boundaries are floor((bnd_lo+bnd_mid)/2) and floor((bnd_mid+bnd_hi)/2), computed without overflow. For example, 40/51/90 gives 45 and 70.
- R3: In temperature mode (`speed_mode`=0), the zone index is the number of the five boundaries that `temp` is strictly greater than (0 to 5), and the target is `zone_cnt[index]`. Index 5 is the hottest zone.
- R4: A target of FFFFh sets `duty` to 00h at the next clock edge, in any state.
- R5: A target of 0000h sets `duty` to FFh at the next clock edge, in any state.
- R6: During closed-loop run, on each `meas_vld` edge: `duty` rises by 1 if `meas_cnt` > target, saturating at FFh; it falls by 1 if `meas_cnt` < target; it is unchanged if they are equal. Without `meas_vld`, `duty` does not change.
- R7: A step from 01h to 00h starts a stop hold. During the hold, `duty` stays 00h and strobes are ignored until `hold_ticks` ticks have passed.
- R8: A strobe with `meas_cnt` > target while `duty` is 00h in run sets `duty` to `start_duty` (01h if `start_duty` is 0). `duty` then stays there, ignoring strobes, for `hold_ticks` ticks.
- R9: In speed mode (`speed_mode`=1), the target is `speed_cnt`, and the zone counts and temperature have no effect.
- R10: `fan_fault` is 1 exactly when `duty` is FFh, the latest strobed `meas_cnt` was above the target, and this has lasted `fault_ticks` ticks. It clears as soon as either condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| speed_mode | input | 1 | 1: target is speed_cnt; 0: target from temperature zones |
| temp | input | 8 | Temperature reading |
| bnd_lo | input | 8 | Lowest programmed boundary |
| bnd_mid | input | 8 | Middle programmed boundary |
| bnd_hi | input | 8 | Highest programmed boundary |
| zone_cnt | input | 6x16 | Target count per zone, index 0 coolest |
| speed_cnt | input | 16 | Target count in speed mode |
| meas_cnt | input | 16 | Measured tachometer count |
| meas_vld | input | 1 | Strobe: meas_cnt holds a new measurement |
| start_duty | input | 8 | Duty applied when the fan restarts from 00h |
| hold_ticks | input | 8 | Stop/start hold length in ticks |
| fault_ticks | input | 8 | Full-duty time before a fault, in ticks |
| duty | output | 8 | Duty register value |
| fan_fault | output | 1 | Fan failed to reach target at full duty |

## Verification
Zone lookup is checked with temperatures just below, at and just above each boundary. The checked zone count is set to FFFFh and all others to 0000h, so a wrong zone shows up as FFh instead of 00h on `duty`. A second boundary set with odd sums separates floor averaging from rounding. Measurements below, equal to and above the target show the direction and size of each step and saturation at FFh. Strobes sent during the stop and start holds show whether the holds ignore them. The fault flag is observed one tick before and at the programmed period, and again after the fan recovers.

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl #(
  parameter int TW = 8,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 speed_mode,
  input  logic [TW-1:0]        temp,
  input  logic [TW-1:0]        bnd_lo,
  input  logic [TW-1:0]        bnd_mid,
  input  logic [TW-1:0]        bnd_hi,
  input  logic [5:0][CW-1:0]   zone_cnt,
  input  logic [CW-1:0]        speed_cnt,
  input  logic [CW-1:0]        meas_cnt,
  input  logic                 meas_vld,
  input  logic [DW-1:0]        start_duty,
  input  logic [HW-1:0]        hold_ticks,
  input  logic [HW-1:0]        fault_ticks,
  output logic [DW-1:0]        duty,
  output logic                 fan_fault
);
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic [DW-1:0] DONE = DW'(1);

  typedef enum logic [1:0] {RUN, STOP_HOLD, START_HOLD} st_t;

  st_t          st;
  logic [HW-1:0] hcnt, fcnt;
  logic          slow;

  logic [TW:0]   sum_a, sum_b;
  logic [TW-1:0] mid_a, mid_b;
  logic [2:0]    zone;
  logic [CW-1:0] tgt;
  logic          force_off, force_full, faster, slower;
  logic [DW-1:0] start_eff;

  assign sum_a = {1'b0, bnd_lo} + {1'b0, bnd_mid};
  assign sum_b = {1'b0, bnd_mid} + {1'b0, bnd_hi};
  assign mid_a = sum_a[TW:1];
  assign mid_b = sum_b[TW:1];

  assign zone = {2'b0, temp > bnd_lo} + {2'b0, temp > mid_a} + {2'b0, temp > bnd_mid}
              + {2'b0, temp > mid_b} + {2'b0, temp > bnd_hi};

  assign tgt        = speed_mode ? speed_cnt : zone_cnt[zone];
  assign force_off  = &tgt;
  assign force_full = ~|tgt;
  assign slower     = meas_cnt > tgt;
  assign faster     = meas_cnt < tgt;
  assign start_eff  = (start_duty == '0) ? DONE : start_duty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty <= DMAX;
      st   <= RUN;
      hcnt <= '0;
    end else if (force_off) begin
      duty <= '0;
      st   <= RUN;
    end else if (force_full) begin
      duty <= DMAX;
      st   <= RUN;
    end else if (st != RUN) begin
      if (hcnt == hold_ticks) st <= RUN;
      else if (tick)          hcnt <= hcnt + HW'(1);
    end else if (meas_vld) begin
      if (slower) begin
        if (duty == '0) begin
          duty <= start_eff;
          st   <= START_HOLD;
          hcnt <= '0;
        end else if (duty != DMAX) begin
          duty <= duty + DONE;
        end
      end else if (faster) begin
        if (duty == DONE) begin
          duty <= '0;
          st   <= STOP_HOLD;
          hcnt <= '0;
        end else if (duty != '0) begin
          duty <= duty - DONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow <= 1'b0;
      fcnt <= '0;
    end else begin
      if (meas_vld) slow <= slower;
      if (duty == DMAX && slow) begin
        if (tick && fcnt != fault_ticks) fcnt <= fcnt + HW'(1);
      end else begin
        fcnt <= '0;
      end
    end
  end

  assign fan_fault = (duty == DMAX) && slow && (fcnt == fault_ticks);
endmodule

module fan_duty_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          force_off,
  input logic          force_full,
  input logic [DW-1:0] duty,
  input logic          fan_fault
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (duty == '1 && !fan_fault));

  assert_off_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> duty == '0);

  assert_full_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_full && !force_off) |=> duty == '1);

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !force_off && !force_full && duty > DW'(1)) |=>
      (duty == $past(duty) || duty == $past(duty) + DW'(1) || duty == $past(duty) - DW'(1)));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0 && !force_off && !force_full) |=> $stable(duty));

  assert_fault_at_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fan_fault |-> duty == '1);
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .force_off(force_off),
  .force_full(force_full), .duty(duty), .fan_fault(fan_fault)
);

// File: tb/test_fan_duty_ctrl.sv
module test_fan_duty_ctrl;
  logic clk = 0, rst_n = 0, tick = 0, speed_mode = 1, meas_vld = 0;
  logic [7:0] temp = 0, bnd_lo = 40, bnd_mid = 50, bnd_hi = 90;
  logic [5:0][15:0] zone_cnt = '0;
  logic [15:0] speed_cnt = 16'd1000, meas_cnt = 0;
  logic [7:0] start_duty = 8'h40, hold_ticks = 8'd3, fault_ticks = 8'd4;
  logic [7:0] duty;
  logic fan_fault;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fan_duty_ctrl i_fan_duty_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .speed_mode(speed_mode), .temp(temp),
    .bnd_lo(bnd_lo), .bnd_mid(bnd_mid), .bnd_hi(bnd_hi), .zone_cnt(zone_cnt),
    .speed_cnt(speed_cnt), .meas_cnt(meas_cnt), .meas_vld(meas_vld),
    .start_duty(start_duty), .hold_ticks(hold_ticks), .fault_ticks(fault_ticks),
    .duty(duty), .fan_fault(fan_fault)
  );

  // temp, expected zone with boundaries 40/50/90 (midpoints 45/70)
  localparam logic [10:0] VEC [12] = '{
    {8'd0, 3'd0}, {8'd40, 3'd0}, {8'd41, 3'd1}, {8'd45, 3'd1},
    {8'd46, 3'd2}, {8'd50, 3'd2}, {8'd51, 3'd3}, {8'd70, 3'd3},
    {8'd71, 3'd4}, {8'd90, 3'd4}, {8'd91, 3'd5}, {8'd255, 3'd5}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] m);
    meas_cnt = m; meas_vld = 1;
    @(negedge clk);
    meas_vld = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  task automatic pick_zone(input int z);
    for (int k = 0; k < 6; k++) zone_cnt[k] = (k == z) ? 16'hFFFF : 16'h0000;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(duty == 8'hFF, "R1 duty", duty, 8'hFF);
    chk(fan_fault == 0, "R1 fault", fan_fault, 0);

    // R6 closed loop
    strobe(16'd900);
    chk(duty == 8'hFE, "R6 dec", duty, 8'hFE);
    cyc(3);
    chk(duty == 8'hFE, "R6 no strobe", duty, 8'hFE);
    strobe(16'd1000);
    chk(duty == 8'hFE, "R6 equal", duty, 8'hFE);
    strobe(16'd1100);
    chk(duty == 8'hFF, "R6 inc", duty, 8'hFF);
    strobe(16'd1100);
    chk(duty == 8'hFF, "R6 saturate", duty, 8'hFF);

    // R10 fault
    ticks(3);
    chk(fan_fault == 0, "R10 before period", fan_fault, 0);
    ticks(1);
    chk(fan_fault == 1, "R10 at period", fan_fault, 1);
    strobe(16'd900);
    chk(fan_fault == 0 && duty == 8'hFE, "R10 clear", {fan_fault, duty}, 9'h0FE);

    // R7 stop hold
    for (int i = 0; i < 253; i++) strobe(16'd900);
    chk(duty == 8'h01, "R6 walk down", duty, 8'h01);
    strobe(16'd900);
    chk(duty == 8'h00, "R7 reach stop", duty, 8'h00);
    strobe(16'd1100);
    chk(duty == 8'h00, "R7 strobe ignored", duty, 8'h00);
    ticks(3);
    cyc(2);

    // R8 start hold
    strobe(16'd1100);
    chk(duty == 8'h40, "R8 start duty", duty, 8'h40);
    strobe(16'd900);
    chk(duty == 8'h40, "R8 hold ignores", duty, 8'h40);
    ticks(3);
    cyc(2);
    strobe(16'd900);
    chk(duty == 8'h3F, "R8 loop resumes", duty, 8'h3F);

    // R4 / R5
    speed_cnt = 16'hFFFF; cyc(1);
    chk(duty == 8'h00, "R4 off code", duty, 8'h00);
    speed_cnt = 16'h0000; cyc(1);
    chk(duty == 8'hFF, "R5 full code", duty, 8'hFF);

    // R9 speed mode ignores zones
    speed_cnt = 16'd1000;
    for (int k = 0; k < 6; k++) zone_cnt[k] = 16'hFFFF;
    temp = 8'd60; cyc(3);
    chk(duty == 8'hFF, "R9 zones ignored", duty, 8'hFF);
    speed_mode = 0; cyc(1);
    chk(duty == 8'h00, "R9 temp mode", duty, 8'h00);

    // R3 zone table
    foreach (VEC[v]) begin
      pick_zone(int'(VEC[v][2:0]));
      temp = VEC[v][10:3];
      cyc(2);
      chk(duty == 8'h00, $sformatf("R3 temp %0d zone %0d", VEC[v][10:3], VEC[v][2:0]), duty, 8'h00);
      for (int k = 0; k < 6; k++) zone_cnt[k] = 16'h0000;
      cyc(1);
    end

    // R2 floor averaging with odd sums: 40/51/90 -> 45/70
    bnd_mid = 51;
    pick_zone(1); temp = 45; cyc(2);
    chk(duty == 8'h00, "R2 low midpoint floor", duty, 8'h00);
    pick_zone(2); temp = 46; cyc(2);
    chk(duty == 8'h00, "R2 above low midpoint", duty, 8'h00);
    pick_zone(3); temp = 70; cyc(2);
    chk(duty == 8'h00, "R2 high midpoint floor", duty, 8'h00);
    pick_zone(4); temp = 71; cyc(2);
    chk(duty == 8'h00, "R2 above high midpoint", duty, 8'h00);

    finish_run();
  end
endmodule